// File: doc/BRIEF.md
# Memory-to-Memory Byte Move Sequencer

This block carries out a single byte transfer from one memory location to another over a plain synchronous memory port. It is started by a one-cycle pulse that comes with a two-bit variant code, the two operand bytes that follow the opcode, and the current 16-bit index value. The variant selects where the byte comes from (a page-zero location, the index, or the first operand byte itself) and where it goes (a page-zero location or the index). The sequencer issues the source read, holds the returned byte, issues the destination write, and then pulses `done` with the updated index on `idx_out`.

Page-zero addresses are formed by putting a zero high byte above an operand byte, so they can only reach 0x0000 through 0x00FF. The two variants that use the index also step it by one. The step is taken at a different point for each of them: right after the source read when the index is the source, and right after the destination write when the index is the destination. Memory read data arrives one cycle after the address is presented.

Top module: `mem_move_seq`

## Requirements
- R1: After reset `done` and `mem_we` are 0 and `idx_out` is 0x0000.
- R2: Variant 2'b00 (page zero to page zero) reads at {0x00, op0} and then writes that byte to {0x00, op1}. `idx_out` at `done` equals the index given at start.
- R3: Variant 2'b01 (constant to page zero) writes op0 to {0x00, op1} without a read cycle. `done` rises 2 cycles after the start edge, against 4 cycles for the other variants.
- R4: Variant 2'b10 (index source with step) reads at the index and writes to {0x00, op0}. `idx_out` already shows index+1 in the write cycle.
- R5: Variant 2'b11 (index destination with step) reads at {0x00, op0} and writes to the index. `idx_out` shows the unchanged index in the write cycle and index+1 at `done`.
- R6: Every page-zero address that is driven has a high byte of 0x00, including for operand 0xFF.
- R7: Read data is taken from the memory one cycle after the read address, and the held byte is written even when the memory output has changed since then. A move that reads a location written by the previous move gets the new byte.
- R8: Each move gives exactly one write cycle, and `done` is a single-cycle pulse in the cycle after that write.
- R9: A start pulse while a move is in progress, including its `done` cycle, is ignored. No further write or `done` follows from it.
- R10: The index step wraps modulo 65536 (0xFFFF becomes 0x0000) and is applied exactly once per move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a move, taken only when idle |
| variant | input | 2 | Source/destination pairing (see R2 to R5) |
| op0 | input | 8 | First operand byte |
| op1 | input | 8 | Second operand byte |
| idx_in | input | 16 | Index value at start |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| idx_out | output | 16 | Index value, updated during the move |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check on every cycle that `done` lasts one cycle and always follows a write, and that page-zero write addresses keep a zero high byte. They also check that the latched variant and operands stay fixed while a move runs, that the constant variant never passes through a read, and that each index-stepping variant adds exactly one at its own point. Only the bench scenarios can show the data path end to end. They check that the byte written is the one read from the right source, that the constant variant has the shorter latency, and that the index wraps at 0xFFFF. They also check that a move sees the previous move's write, and that start pulses during a move produce no extra write.

// File: rtl/mm_move_pkg.sv
package mm_move_pkg;

    typedef enum logic [1:0] {
        MV_DIR_DIR = 2'b00,
        MV_IMM_DIR = 2'b01,
        MV_IDX_DIR = 2'b10,
        MV_DIR_IDX = 2'b11
    } mv_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CAPT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } mv_state_e;

endpackage

// File: rtl/mm_addr_sel.sv
module mm_addr_sel
    import mm_move_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  mv_kind_e        kind,
    input  logic [DW-1:0]   op0,
    input  logic [DW-1:0]   op1,
    input  logic [AW-1:0]   idx,
    output logic [AW-1:0]   src_addr,
    output logic [AW-1:0]   dst_addr
);
    localparam int HW = AW - DW;

    logic [AW-1:0] page_op0;
    logic [AW-1:0] page_op1;

    // page-zero forms: operand byte with all-zero upper bits
    assign page_op0 = {{HW{1'b0}}, op0};
    assign page_op1 = {{HW{1'b0}}, op1};

    always_comb begin
        src_addr = page_op0;
        dst_addr = page_op1;
        case (kind)
            MV_DIR_DIR: begin
                src_addr = page_op0;
                dst_addr = page_op1;
            end
            MV_IMM_DIR: begin
                src_addr = page_op0;   // unused: no read issued
                dst_addr = page_op1;
            end
            MV_IDX_DIR: begin
                src_addr = idx;
                dst_addr = page_op0;
            end
            MV_DIR_IDX: begin
                src_addr = page_op0;
                dst_addr = idx;
            end
            default: begin
                src_addr = page_op0;
                dst_addr = page_op1;
            end
        endcase
    end
endmodule

// File: rtl/mm_idx_step.sv
module mm_idx_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // modulo 2**AW increment; carry out is dropped on purpose
    assign nxt = cur + ONE;
endmodule

// File: rtl/mem_move_seq.sv
module mem_move_seq
    import mm_move_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    variant,
    input  logic [DW-1:0] op0,
    input  logic [DW-1:0] op1,
    input  logic [AW-1:0] idx_in,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [AW-1:0] idx_out,
    output logic          done
);
    localparam int HW = AW - DW;

    typedef struct packed {
        mv_state_e     st;
        mv_kind_e      kind;
        logic [DW-1:0] op0;
        logic [DW-1:0] op1;
        logic [AW-1:0] idx;
        logic [DW-1:0] hold;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;
    logic [AW-1:0] idx_plus;

    mm_addr_sel #(.AW(AW), .DW(DW)) u_addr (
        .kind     (r_q.kind),
        .op0      (r_q.op0),
        .op1      (r_q.op1),
        .idx      (r_q.idx),
        .src_addr (src_addr),
        .dst_addr (dst_addr)
    );

    mm_idx_step #(.AW(AW)) u_step (
        .cur (r_q.idx),
        .nxt (idx_plus)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.kind = mv_kind_e'(variant);
                    r_d.op0  = op0;
                    r_d.op1  = op1;
                    r_d.idx  = idx_in;
                    if (mv_kind_e'(variant) == MV_IMM_DIR) begin
                        r_d.hold = op0;
                        r_d.st   = ST_WRITE;
                    end else begin
                        r_d.st   = ST_READ;
                    end
                end
            end
            ST_READ: begin
                r_d.st = ST_CAPT;
                if (r_q.kind == MV_IDX_DIR) begin
                    r_d.idx = idx_plus;      // step right after the source read
                end
            end
            ST_CAPT: begin
                r_d.hold = mem_rdata;        // one-cycle read latency
                r_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.st = ST_DONE;
                if (r_q.kind == MV_DIR_IDX) begin
                    r_d.idx = idx_plus;      // step right after the destination write
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, kind: MV_DIR_DIR, op0: '0, op1: '0, idx: '0, hold: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = (r_q.st == ST_WRITE) ? dst_addr : src_addr;
    assign mem_wdata = r_q.hold;
    assign mem_we    = (r_q.st == ST_WRITE);
    assign idx_out   = r_q.idx;
    assign done      = (r_q.st == ST_DONE);

    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: every write is followed by done
    p_write_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);

    // R6: page-zero destinations keep a zero high byte
    p_direct_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && r_q.kind != MV_DIR_IDX) |-> (mem_addr[AW-1:DW] == {HW{1'b0}}));

    // R9: the latched command stays fixed while busy
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_DONE)
            |=> ($stable(r_q.kind) && $stable(r_q.op0) && $stable(r_q.op1)));

    // R3: constant variant reaches its write directly from idle
    p_imm_skip_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WRITE && r_q.kind == MV_IMM_DIR) |-> ($past(r_q.st) == ST_IDLE));

    // R4 / R10: index source variant has stepped once by its write cycle
    p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && r_q.kind == MV_IDX_DIR) |-> (idx_out == AW'($past(idx_out, 2) + 1'b1)));

    // R5 / R10: index destination variant steps once after its write
    p_dst_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.kind == MV_DIR_IDX) |-> (idx_out == AW'($past(idx_out) + 1'b1)));

endmodule

// File: tb/mem_move_seq_tb.sv
module mem_move_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  variant = 2'b00;
    logic [7:0]  op0 = '0;
    logic [7:0]  op1 = '0;
    logic [15:0] idx_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [15:0] idx_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int n_writes = 0;
    int n_moves  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_move_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
        .op0(op0), .op1(op1), .idx_in(idx_in), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .idx_out(idx_out), .done(done)
    );

    // memory model: sparse store over a computed background pattern
    logic [7:0] mem [int];

    function automatic logic [7:0] peek(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= peek(mem_addr);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    typedef struct {
        int          req;
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [15:0] idx_w;
        logic [15:0] idx_f;
    } exp_t;

    exp_t sb[$];

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(8, "done longer than one cycle", 1, 0);
            if (mem_we) begin
                n_writes++;
                if (sb.size() == 0) begin
                    check(9, "unexpected write", 1, 0);
                end else begin
                    check(sb[0].req, "write address", mem_addr, sb[0].waddr);
                    check(sb[0].req, "write data", mem_wdata, sb[0].wdata);
                    check(sb[0].req, "index in write cycle", idx_out, sb[0].idx_w);
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(9, "unexpected done", 1, 0);
                end else begin
                    check(sb[0].req, "index at done", idx_out, sb[0].idx_f);
                    void'(sb.pop_front());
                end
            end
            prev_done = done;
        end
    end

    // driver: intr is the cycle count at which a stray start is pulsed (0 = none)
    task automatic do_move(input int req, input logic [1:0] v, input logic [7:0] a,
                           input logic [7:0] b, input logic [15:0] ix, input int intr);
        exp_t e;
        int lat;
        int n;
        e.req = req;
        case (v)
            2'b00: begin e.waddr = {8'h00, b}; e.wdata = peek({8'h00, a}); e.idx_w = ix; e.idx_f = ix; end
            2'b01: begin e.waddr = {8'h00, b}; e.wdata = a;                e.idx_w = ix; e.idx_f = ix; end
            2'b10: begin e.waddr = {8'h00, a}; e.wdata = peek(ix);         e.idx_w = ix + 16'd1; e.idx_f = ix + 16'd1; end
            default: begin e.waddr = ix;       e.wdata = peek({8'h00, a}); e.idx_w = ix; e.idx_f = ix + 16'd1; end
        endcase
        lat = (v == 2'b01) ? 2 : 4;
        sb.push_back(e);
        n_moves++;
        @(negedge clk);
        start = 1'b1; variant = v; op0 = a; op1 = b; idx_in = ix;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (n == intr) begin
                start = 1'b1; variant = ~v; op0 = ~a; op1 = ~b; idx_in = ~ix;
            end
        end while (!done && n < 12);
        check(v == 2'b01 ? 3 : 8, "cycles from start to done", n, lat);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, "done in reset", done, 0);
        check(1, "write enable in reset", mem_we, 0);
        check(1, "index in reset", idx_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "done after reset", done, 0);
        check(1, "index after reset", idx_out, 16'h0000);

        do_move(2, 2'b00, 8'h10, 8'h20, 16'h1234, 0);   // R2
        do_move(2, 2'b00, 8'hFF, 8'h00, 16'hABCD, 0);   // R2, R6 edge operand
        do_move(3, 2'b01, 8'hC3, 8'h40, 16'h0042, 0);   // R3
        do_move(6, 2'b01, 8'h00, 8'hFF, 16'h7777, 0);   // R6 top of page zero
        do_move(4, 2'b10, 8'h50, 8'h99, 16'h8001, 0);   // R4
        do_move(5, 2'b11, 8'h40, 8'h00, 16'h3000, 0);   // R5 reads byte from R3 move
        do_move(7, 2'b00, 8'h20, 8'h60, 16'h0000, 0);   // R7 reads byte written by R2 move
        do_move(7, 2'b10, 8'h61, 8'h00, 16'h3000, 0);   // R7 reads byte written by R5 move
        do_move(10, 2'b10, 8'h70, 8'h00, 16'hFFFF, 0);  // R10 wrap on source step
        do_move(10, 2'b11, 8'h71, 8'h00, 16'hFFFF, 0);  // R10 wrap on destination step
        do_move(9, 2'b00, 8'h11, 8'h22, 16'h0101, 2);   // R9 start during capture
        do_move(9, 2'b11, 8'h12, 8'h00, 16'h2000, 4);   // R9 start during done
        do_move(9, 2'b01, 8'hA5, 8'h33, 16'h0202, 1);   // R9 start during write

        repeat (6) @(negedge clk);
        check(9, "pending expected moves", sb.size(), 0);
        check(8, "one write per move", n_writes, n_moves);
        check(8, "done idle after moves", done, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule